// File: doc/BRIEF.md
# Dual-Direction Mailbox Bypass Channel

This block gives two independently clocked ports a way to hand single words to each other without going through a queue. Each direction has one word register. Port A deposits words that port B collects, and port B deposits words that port A collects. A mailbox-select input on each port marks an access as a mailbox access. Any access without it belongs to other logic and leaves the mailboxes untouched.

Each mailbox has a new-mail condition. The writer sees it as a full flag in its own clock domain. The flag sets on the edge that accepts the word and stays set until the reader has taken the word. The reader sees a ready flag in its own domain. That flag rises once the write has crossed the synchronizer and drops on the edge of the read. The crossing uses a toggle handshake: one toggle bit per side, each passed through a small synchronizer chain. While the full flag is set, a new write is refused, so an unread word is never overwritten. Reset clears both handshakes.

Top module: `mailbox_pair`

## Requirements
- R1: While rstN is low and after its release, mbx1Full, mbx1Ready, mbx2Full, mbx2Ready are 0 and doutA and doutB are all zeros.
- R2: A port-A write is selA=1, enA=1, wrA=1 and mbxA=1 on a clkA rising edge. When mbx1Full is 0 it captures dinA into mailbox 1, and mbx1Full reads 1 right after that edge.
- R3: A port-A write while mbx1Full is 1 is ignored. The stored word is not changed and mbx1Full stays 1.
- R4: After an accepted write to mailbox 1, mbx1Ready is 1 no later than the SYNC_STAGES-th clkB rising edge that follows the write edge.
- R5: A port-B read is selB=1, enB=1, wrB=0 and mbxB=1 on a clkB rising edge. It puts the mailbox-1 word on doutB right after that edge. If mbx1Ready was 1, mbx1Ready reads 0 right after the edge, and mbx1Full returns to 0 no later than the SYNC_STAGES-th following clkA rising edge.
- R6: An access with any of select, enable or mailbox-select at 0 changes neither mailbox, its flags nor doutA/doutB.
- R7: A mailbox read while the ready flag is 0 still shows the stored word on the dout port, and it changes neither flag.
- R8: Mailbox 2 mirrors mailbox 1 with the ports swapped. Port B writes it (wrB=1) under mbx2Full in the clkB domain. Port A reads it (wrA=0) onto doutA under mbx2Ready in the clkA domain.
- R9: doutA changes only on a clkA edge with a port-A mailbox read, and doutB changes only on a clkB edge with a port-B mailbox read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock, unrelated to clkA |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| selA | input | 1 | Port A select |
| enA | input | 1 | Port A enable |
| wrA | input | 1 | Port A direction, 1 write, 0 read |
| mbxA | input | 1 | Port A mailbox select |
| dinA | input | WIDTH | Word written into mailbox 1 |
| doutA | output | WIDTH | Last word read from mailbox 2 |
| mbx1Full | output | 1 | Mailbox 1 holds unread mail (clkA domain) |
| mbx2Ready | output | 1 | Mailbox 2 has mail to collect (clkA domain) |
| selB | input | 1 | Port B select |
| enB | input | 1 | Port B enable |
| wrB | input | 1 | Port B direction, 1 write, 0 read |
| mbxB | input | 1 | Port B mailbox select |
| dinB | input | WIDTH | Word written into mailbox 2 |
| doutB | output | WIDTH | Last word read from mailbox 1 |
| mbx2Full | output | 1 | Mailbox 2 holds unread mail (clkB domain) |
| mbx1Ready | output | 1 | Mailbox 1 has mail to collect (clkB domain) |

## Verification
The properties assume that each port's control inputs are settled around the rising edge of that port's own clock, and that both domains see the same reset release. Under those conditions the full-set, ready-clear and output-hold rules follow from the toggle handshake. The stimulus changes every port-A input on a clkA falling edge and every port-B input on a clkB falling edge. The two clocks run at unrelated periods, so the handshake crossings land at changing phase offsets through the sweep.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic loadAB;
    logic loadBA;
    logic readAB;
    logic readBA;
  } mbxStrobes_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clkA,
  input  logic        clkB,
  input  logic        rstN,
  input  logic        selA,
  input  logic        enA,
  input  logic        wrA,
  input  logic        mbxA,
  input  logic        selB,
  input  logic        enB,
  input  logic        wrB,
  input  logic        mbxB,
  output mbxStrobes_t strobes,
  output logic        mbx1Full,
  output logic        mbx1Ready,
  output logic        mbx2Full,
  output logic        mbx2Ready
);
  localparam int NUM_DIR = 2;

  logic accessA, accessB;
  logic [NUM_DIR-1:0] wrClk, rdClk, wrOp, rdOp;
  logic [NUM_DIR-1:0] full, ready, load;

  assign accessA = selA & enA & mbxA;
  assign accessB = selB & enB & mbxB;

  // direction 0: A writes, B reads; direction 1: B writes, A reads
  assign wrClk = {clkB, clkA};
  assign rdClk = {clkA, clkB};
  assign wrOp  = {accessB & wrB, accessA & wrA};
  assign rdOp  = {accessA & ~wrA, accessB & ~wrB};

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      logic wTog, rTog, wTogAtR, rTogAtW;

      always_ff @(posedge wrClk[d] or negedge rstN) begin
        if (!rstN)        wTog <= 1'b0;
        else if (load[d]) wTog <= ~wTog;
      end

      always_ff @(posedge rdClk[d] or negedge rstN) begin
        if (!rstN)                    rTog <= 1'b0;
        else if (rdOp[d] && ready[d]) rTog <= ~rTog;
      end

      mbx_sync #(.STAGES(SYNC_STAGES)) u_toReader (
        .clk(rdClk[d]), .rstN(rstN), .d(wTog), .q(wTogAtR)
      );
      mbx_sync #(.STAGES(SYNC_STAGES)) u_toWriter (
        .clk(wrClk[d]), .rstN(rstN), .d(rTog), .q(rTogAtW)
      );

      assign full[d]  = wTog ^ rTogAtW;
      assign ready[d] = wTogAtR ^ rTog;
      assign load[d]  = wrOp[d] & ~full[d];
    end
  endgenerate

  assign strobes.loadAB = load[0];
  assign strobes.loadBA = load[1];
  assign strobes.readAB = rdOp[0];
  assign strobes.readBA = rdOp[1];

  assign mbx1Full  = full[0];
  assign mbx1Ready = ready[0];
  assign mbx2Full  = full[1];
  assign mbx2Ready = ready[1];
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  mbxStrobes_t      strobes,
  input  logic [WIDTH-1:0] dinA,
  input  logic [WIDTH-1:0] dinB,
  output logic [WIDTH-1:0] doutA,
  output logic [WIDTH-1:0] doutB
);
  logic [WIDTH-1:0] box1, box2;

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      box1  <= '0;
      doutA <= '0;
    end else begin
      if (strobes.loadAB) box1  <= dinA;
      if (strobes.readBA) doutA <= box2;
    end
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      box2  <= '0;
      doutB <= '0;
    end else begin
      if (strobes.loadBA) box2  <= dinB;
      if (strobes.readAB) doutB <= box1;
    end
  end
endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair
  import mbx_pkg::*;
#(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  logic             selA,
  input  logic             enA,
  input  logic             wrA,
  input  logic             mbxA,
  input  logic [WIDTH-1:0] dinA,
  output logic [WIDTH-1:0] doutA,
  output logic             mbx1Full,
  output logic             mbx2Ready,
  input  logic             selB,
  input  logic             enB,
  input  logic             wrB,
  input  logic             mbxB,
  input  logic [WIDTH-1:0] dinB,
  output logic [WIDTH-1:0] doutB,
  output logic             mbx2Full,
  output logic             mbx1Ready
);
  mbxStrobes_t strobes;

  mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .selA(selA), .enA(enA), .wrA(wrA), .mbxA(mbxA),
    .selB(selB), .enB(enB), .wrB(wrB), .mbxB(mbxB),
    .strobes(strobes),
    .mbx1Full(mbx1Full), .mbx1Ready(mbx1Ready),
    .mbx2Full(mbx2Full), .mbx2Ready(mbx2Ready)
  );

  mbx_datapath #(.WIDTH(WIDTH)) u_data (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .strobes(strobes),
    .dinA(dinA), .dinB(dinB),
    .doutA(doutA), .doutB(doutB)
  );
endmodule

// File: rtl/mailbox_pair_chk.sv
module mailbox_pair_chk #(
  parameter int WIDTH = 36
) (
  input logic             clkA,
  input logic             clkB,
  input logic             rstN,
  input logic             selA,
  input logic             enA,
  input logic             wrA,
  input logic             mbxA,
  input logic [WIDTH-1:0] doutA,
  input logic             mbx1Full,
  input logic             mbx2Ready,
  input logic             selB,
  input logic             enB,
  input logic             wrB,
  input logic             mbxB,
  input logic [WIDTH-1:0] doutB,
  input logic             mbx2Full,
  input logic             mbx1Ready
);
  logic mbxWrA, mbxRdA, mbxWrB, mbxRdB;
  assign mbxWrA = selA & enA & mbxA & wrA;
  assign mbxRdA = selA & enA & mbxA & ~wrA;
  assign mbxWrB = selB & enB & mbxB & wrB;
  assign mbxRdB = selB & enB & mbxB & ~wrB;

  a_r2_full_sets: assert property (@(posedge clkA) disable iff (!rstN)
    (mbxWrA && !mbx1Full) |=> mbx1Full);

  a_r8_full2_sets: assert property (@(posedge clkB) disable iff (!rstN)
    (mbxWrB && !mbx2Full) |=> mbx2Full);

  a_r5_ready_drops: assert property (@(posedge clkB) disable iff (!rstN)
    (mbxRdB && mbx1Ready) |=> !mbx1Ready);

  a_r8_ready2_drops: assert property (@(posedge clkA) disable iff (!rstN)
    (mbxRdA && mbx2Ready) |=> !mbx2Ready);

  a_r9_doutb_holds: assert property (@(posedge clkB) disable iff (!rstN)
    !mbxRdB |=> $stable(doutB));

  a_r9_douta_holds: assert property (@(posedge clkA) disable iff (!rstN)
    !mbxRdA |=> $stable(doutA));
endmodule

bind mailbox_pair mailbox_pair_chk #(.WIDTH(WIDTH)) u_chk (
  .clkA(clkA), .clkB(clkB), .rstN(rstN),
  .selA(selA), .enA(enA), .wrA(wrA), .mbxA(mbxA),
  .doutA(doutA), .mbx1Full(mbx1Full), .mbx2Ready(mbx2Ready),
  .selB(selB), .enB(enB), .wrB(wrB), .mbxB(mbxB),
  .doutB(doutB), .mbx2Full(mbx2Full), .mbx1Ready(mbx1Ready)
);

// File: tb/test_mailbox_pair.sv
module test_mailbox_pair;
  localparam int W = 36;
  localparam int ITER = 9;

  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b0;
  logic selA = 0, enA = 0, wrA = 0, mbxA = 0;
  logic selB = 0, enB = 0, wrB = 0, mbxB = 0;
  logic [W-1:0] dinA = '0, dinB = '0;
  logic [W-1:0] doutA, doutB;
  logic mbx1Full, mbx1Ready, mbx2Full, mbx2Ready;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clkA = ~clkA;   // 125 MHz
  always #6.5 clkB = ~clkB; // unrelated rate

  mailbox_pair #(.WIDTH(W), .SYNC_STAGES(2)) i_mailbox_pair (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .selA(selA), .enA(enA), .wrA(wrA), .mbxA(mbxA),
    .dinA(dinA), .doutA(doutA), .mbx1Full(mbx1Full), .mbx2Ready(mbx2Ready),
    .selB(selB), .enB(enB), .wrB(wrB), .mbxB(mbxB),
    .dinB(dinB), .doutB(doutB), .mbx2Full(mbx2Full), .mbx1Ready(mbx1Ready)
  );

  function automatic logic [W-1:0] pat(int i, int salt);
    logic [63:0] x;
    x = 64'(i + 1) * 64'h9E3779B97F4A7C15 + 64'(salt) * 64'h0000_00F1_3579_BDF1;
    return x[W-1:0] ^ (x[63:64-W]);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic opA(bit s, bit e, bit w, bit m, logic [W-1:0] d);
    @(negedge clkA);
    selA = s; enA = e; wrA = w; mbxA = m; dinA = d;
    @(negedge clkA);
    selA = 0; enA = 0; wrA = 0; mbxA = 0; dinA = '0;
  endtask

  task automatic opB(bit s, bit e, bit w, bit m, logic [W-1:0] d);
    @(negedge clkB);
    selB = s; enB = e; wrB = w; mbxB = m; dinB = d;
    @(negedge clkB);
    selB = 0; enB = 0; wrB = 0; mbxB = 0; dinB = '0;
  endtask

  task automatic waitA(int n);
    for (int k = 0; k < n; k++) @(negedge clkA);
  endtask

  task automatic waitB(int n);
    for (int k = 0; k < n; k++) @(negedge clkB);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lastA, lastB, e;
    #1;
    chk("R1 reset mbx1Full", W'(mbx1Full), '0);
    chk("R1 reset mbx2Full", W'(mbx2Full), '0);
    chk("R1 reset doutA", doutA, '0);
    chk("R1 reset doutB", doutB, '0);
    #30 rstN = 1'b1;
    waitA(3); waitB(3);
    chk("R1 after release mbx1Ready", W'(mbx1Ready), '0);
    chk("R1 after release mbx2Ready", W'(mbx2Ready), '0);
    chk("R1 after release doutB", doutB, '0);
    lastA = '0; lastB = '0;

    // direction A -> B (mailbox 1)
    for (int i = 0; i < ITER; i++) begin
      e = pat(i, 1);
      opA(1, 1, 1, 1, e);
      chk("R2 mbx1Full after write", W'(mbx1Full), W'(1));
      opA(1, 1, 1, 1, ~e);
      chk("R3 mbx1Full after refused write", W'(mbx1Full), W'(1));
      waitB(3);
      chk("R4 mbx1Ready after sync", W'(mbx1Ready), W'(1));
      opB(1, 1, 0, 0, '0);
      chk("R6 doutB after non-mailbox read", doutB, lastB);
      chk("R6 mbx1Ready after non-mailbox read", W'(mbx1Ready), W'(1));
      opB(1, 1, 0, 1, '0);
      chk("R5 doutB word", doutB, e);
      chk("R3 word not overwritten", doutB, e);
      chk("R5 mbx1Ready cleared", W'(mbx1Ready), '0);
      lastB = e;
      waitA(3);
      chk("R5 mbx1Full cleared", W'(mbx1Full), '0);
      opB(1, 1, 0, 1, '0);
      chk("R7 doutB on empty read", doutB, e);
      chk("R7 mbx1Ready stays low", W'(mbx1Ready), '0);
      waitA(3);
      chk("R7 mbx1Full stays low", W'(mbx1Full), '0);
      case (i % 3)
        0: opA(0, 1, 1, 1, pat(i, 7));
        1: opA(1, 0, 1, 1, pat(i, 7));
        default: opA(1, 1, 1, 0, pat(i, 7));
      endcase
      chk("R6 mbx1Full after partial write", W'(mbx1Full), '0);
      waitB(3);
      chk("R6 mbx1Ready after partial write", W'(mbx1Ready), '0);
      chk("R9 doutA held", doutA, lastA);
      chk("R9 doutB held", doutB, lastB);
    end

    // direction B -> A (mailbox 2)
    for (int i = 0; i < ITER; i++) begin
      e = pat(i, 2);
      opB(1, 1, 1, 1, e);
      chk("R8 mbx2Full after write", W'(mbx2Full), W'(1));
      opB(1, 1, 1, 1, ~e);
      chk("R8 mbx2Full after refused write", W'(mbx2Full), W'(1));
      waitA(3);
      chk("R8 mbx2Ready after sync", W'(mbx2Ready), W'(1));
      opA(1, 0, 0, 1, '0);
      chk("R6 doutA after disabled read", doutA, lastA);
      opA(1, 1, 0, 1, '0);
      chk("R8 doutA word", doutA, e);
      chk("R8 mbx2Ready cleared", W'(mbx2Ready), '0);
      lastA = e;
      waitB(3);
      chk("R8 mbx2Full cleared", W'(mbx2Full), '0);
      opA(1, 1, 0, 1, '0);
      chk("R7 doutA on empty read", doutA, e);
      chk("R7 mbx2Ready stays low", W'(mbx2Ready), '0);
      case (i % 3)
        0: opB(0, 1, 1, 1, pat(i, 9));
        1: opB(1, 0, 1, 1, pat(i, 9));
        default: opB(1, 1, 1, 0, pat(i, 9));
      endcase
      chk("R6 mbx2Full after partial write", W'(mbx2Full), '0);
      waitA(3);
      chk("R6 mbx2Ready after partial write", W'(mbx2Ready), '0);
      chk("R9 doutB held during mailbox 2", doutB, lastB);
    end

    // both directions in flight together
    fork
      opA(1, 1, 1, 1, pat(40, 3));
      opB(1, 1, 1, 1, pat(41, 3));
    join
    waitA(4); waitB(4);
    chk("R4 mbx1Ready concurrent", W'(mbx1Ready), W'(1));
    chk("R8 mbx2Ready concurrent", W'(mbx2Ready), W'(1));
    fork
      opA(1, 1, 0, 1, '0);
      opB(1, 1, 0, 1, '0);
    join
    chk("R5 doutB concurrent", doutB, pat(40, 3));
    chk("R8 doutA concurrent", doutA, pat(41, 3));
    waitA(4); waitB(4);
    chk("R5 mbx1Full concurrent clear", W'(mbx1Full), '0);
    chk("R8 mbx2Full concurrent clear", W'(mbx2Full), '0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule